// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management side of an Ethernet MAC. Software configures it with an enable bit and a clock-divider selection, then loads one 32-bit management word that holds the start code, the opcode, a 5-bit PHY address, a 5-bit register address, the turnaround pattern and 16 data bits. The block serialises a 32-bit preamble of ones followed by that word onto the MDIO line, clocked by MDC. On a read it releases the line for the turnaround and data bits. It collects the PHY's reply into the low half of the same word.

MDC is derived from the system clock by dividing it by 8, 16, 32 or 64. A faster system clock needs a larger ratio to keep MDC at or below 2.5 MHz. As a guide, use 64 above 80 MHz, 32 above 40 MHz, 16 above 20 MHz and 8 below that. The `idle` output is low for the whole of a frame. Software polls it and then reads `mgmt_word`.

Top module: `mdio_master`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `mgmt_word` is zero.
- R2: During a frame, MDC has a period of 8 << `cfg_div_sel` system clocks, with equal high and low halves. The divider value is captured when the frame starts.
- R3: A frame is 64 MDC bits: 32 ones, then `cmd_word` from bit 31 down to bit 0. The word layout is: [31:30] start code, [29:28] opcode (10 = read, 01 = write), [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data. The line is sampled on the rising edge of MDC.
- R4: `mdio_o` and `mdio_oe` change only while MDC is low. They never change at a rising MDC edge.
- R5: On a read, `mdio_oe` is low for the last 18 bits of the frame (turnaround and data). On a write, `mdio_oe` is high for all 64 bits.
- R6: When a read ends, `mgmt_word[15:0]` holds the 16 bits sampled from `mdio_i`, first sampled bit in bit 15. `mgmt_word[31:16]` keeps the loaded value throughout.
- R7: A frame is accepted when `cmd_wr` is high and the port is enabled and idle. `idle` then drops on the next clock and stays low for exactly 64 MDC periods.
- R8: A `cmd_wr` while a frame is in progress is ignored. Neither the frame on the line nor `mgmt_word` changes.
- R9: A `cmd_wr` while the port enable bit is clear is ignored. No MDC edge occurs and `idle` stays high.
- R10: Writing the configuration with the enable bit clear aborts any frame. On the next clock `idle` is 1, MDC is 0 and MDIO is released.
- R11: Whenever `idle` is 1, `mdc` is 0 and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_port_en | input | 1 | Management-port enable value |
| cfg_div_sel | input | 2 | MDC divider select: 0=/8, 1=/16, 2=/32, 3=/64 |
| cmd_wr | input | 1 | Write strobe for the management word; starts a frame |
| cmd_word | input | 32 | Management word to send |
| mgmt_word | output | 32 | Management word readback; the low half holds read data |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |

## Verification
A wrong bit index or a drifting divider count shows up on the first frame. It appears as a wrong bit in the captured MDIO sequence, or as an MDC period that differs from 8 << sel clocks. Either shows within one MDC period of the fault. A busy flag stuck high keeps `idle` low beyond 64 periods, and a stuck-low flag raises `idle` early. Both are visible as a frame length that does not equal 64·N cycles. A release point that is too early or too late changes the sampled read data in `mgmt_word`, and that appears as soon as the frame ends.

// File: rtl/mdio_pkg.sv
// Package: shared frame constants and the frame state type.
// Assumes the Clause 22 frame: 32 preamble bits plus a 32-bit word.
package mdio_pkg;
    localparam int WORD_W     = 32;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + WORD_W;
    localparam int DATA_W     = 16;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int WSEL_W     = $clog2(WORD_W);
    localparam int OP_HI      = WORD_W - 3;
    localparam int TA_IDX     = FRAME_BITS - DATA_W - 2;
    localparam int DATA_IDX   = FRAME_BITS - DATA_W;

    typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} frame_st_t;
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: divides clk by 1 << (DIV_BASE_LOG + div_sel) while run is high.
// MDC is low for the first half of each bit period and high for the second half.
// Assumes run drops in the same cycle that a frame ends or is aborted.
module mdio_clkgen #(
    parameter int DIV_BASE_LOG = 3,
    parameter int SEL_W        = 2,
    localparam int CNT_W       = DIV_BASE_LOG + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             mdc,
    output logic             rise_pulse,
    output logic             bit_end
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W:0]   full_div;
    logic [CNT_W:0]   half_div;

    // Period length and half point for the selected ratio.
    always_comb begin
        full_div = (CNT_W+1)'(1) << (DIV_BASE_LOG + int'(div_sel));
        half_div = full_div >> 1;
    end

    // Next count: wraps at the end of each period and holds at zero when stopped.
    always_comb begin
        if (!run)
            cnt_nxt = '0;
        else if ({1'b0, cnt_q} == full_div - 1'b1)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_q + 1'b1;
    end

    // Count register and registered, glitch-free MDC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            mdc   <= run && ({1'b0, cnt_nxt} >= half_div);
        end
    end

    // Strobes for the MDC rising edge and for the last cycle of a bit.
    assign rise_pulse = run && ({1'b0, cnt_q} == half_div);
    assign bit_end    = run && ({1'b0, cnt_q} == full_div - 1'b1);
endmodule

// File: rtl/mdio_frame.sv
// Frame engine: sends the preamble and the management word MSB first,
// releases MDIO for the turnaround and data bits of a read, and shifts
// the sampled bits into the low half of the held word.
// Assumes rise_pulse and bit_end never fall in the same cycle.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] start_word,
    input  logic              abort,
    input  logic              rise_pulse,
    input  logic              bit_end,
    input  logic              mdio_i,
    output logic              busy,
    output logic [WORD_W-1:0] word_q,
    output logic              mdio_o,
    output logic              mdio_oe
);
    frame_st_t        st_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pos;
    logic             is_read;
    logic             cur_bit;

    // Decode the opcode and select the current bit.
    // pos[WSEL_W] is set exactly during the preamble.
    always_comb begin
        is_read = (word_q[OP_HI -: 2] == 2'b10);
        pos     = IDX_W'(FRAME_BITS - 1) - idx_q;
        cur_bit = pos[WSEL_W] | word_q[pos[WSEL_W-1:0]];
    end

    // Frame state, bit index and word/readback register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            word_q <= '0;
        end else if (abort) begin
            st_q <= ST_IDLE;
        end else if (st_q == ST_IDLE) begin
            if (start) begin
                st_q   <= ST_SHIFT;
                idx_q  <= '0;
                word_q <= start_word;
            end
        end else begin
            if (rise_pulse && is_read && idx_q >= IDX_W'(DATA_IDX))
                word_q[DATA_W-1:0] <= {word_q[DATA_W-2:0], mdio_i};
            if (bit_end) begin
                if (idx_q == IDX_W'(FRAME_BITS - 1))
                    st_q <= ST_IDLE;
                else
                    idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Pad drive: released for turnaround and data on reads, idle-high otherwise.
    always_comb begin
        busy    = (st_q == ST_SHIFT);
        mdio_oe = busy && !(is_read && idx_q >= IDX_W'(TA_IDX));
        mdio_o  = mdio_oe ? cur_bit : 1'b1;
    end
endmodule

// File: rtl/mdio_master.sv
// Top module of the MDIO master: configuration register, command acceptance,
// MDC generator and frame engine.
// Assumes software waits for idle before it reads back mgmt_word.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_BASE_LOG = 3,
    parameter int SEL_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_port_en,
    input  logic [SEL_W-1:0]  cfg_div_sel,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] mgmt_word,
    output logic              idle,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic             port_en_q;
    logic [SEL_W-1:0] div_sel_q;
    logic [SEL_W-1:0] div_run_q;
    logic             busy;
    logic             start;
    logic             abort;
    logic             rise_pulse;
    logic             bit_end;

    // Command acceptance and abort decode.
    assign start = cmd_wr && port_en_q && !busy;
    assign abort = cfg_wr && !cfg_port_en;

    // Configuration register and the divider captured at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en_q <= 1'b0;
            div_sel_q <= '0;
            div_run_q <= '0;
        end else begin
            if (cfg_wr) begin
                port_en_q <= cfg_port_en;
                div_sel_q <= cfg_div_sel;
            end
            if (start)
                div_run_q <= div_sel_q;
        end
    end

    mdio_clkgen #(
        .DIV_BASE_LOG (DIV_BASE_LOG),
        .SEL_W        (SEL_W)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy && !abort),
        .div_sel    (div_run_q),
        .mdc        (mdc),
        .rise_pulse (rise_pulse),
        .bit_end    (bit_end)
    );

    mdio_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_word (cmd_word),
        .abort      (abort),
        .rise_pulse (rise_pulse),
        .bit_end    (bit_end),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .word_q     (mgmt_word),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    assign idle = !busy;
endmodule

// File: rtl/mdio_master_chk.sv
// Checker for mdio_master: protocol and control invariants at the block edge.
// Bound into every mdio_master instance.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        idle,
    input logic        cmd_wr,
    input logic        port_en_q,
    input logic [31:0] mgmt_word
);
    assert_line_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));

    assert_disable_forces_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en_q |-> idle);

    assert_start_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> ($past(cmd_wr) && $past(port_en_q)));

    assert_upper_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(mgmt_word[31:16]));

    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cmd_wr) |=> $stable(mgmt_word[31:16]));
endmodule

bind mdio_master mdio_master_chk u_chk (.*);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_port_en = 1'b0;
    logic [1:0]  cfg_div_sel = 2'd0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] mgmt_word;
    logic        idle;
    logic        mdc;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_port_en(cfg_port_en),
        .cfg_div_sel(cfg_div_sel), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .mgmt_word(mgmt_word), .idle(idle), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc = 0;
    int rises = 0;
    int last_rise = 0;
    int per_min = 0;
    int per_max = 0;
    logic [15:0] phy_data = '0;
    logic cap_o [64];
    logic cap_oe [64];

    // Fields: sel[44:43] rd[42] phy[41:37] reg[36:32] data[31:16] phy reply[15:0]
    localparam logic [44:0] VEC [0:5] = '{
        {2'd0, 1'b0, 5'd1,  5'd0,  16'h1234, 16'h0000},
        {2'd1, 1'b1, 5'd1,  5'd1,  16'h0000, 16'hA5C3},
        {2'd2, 1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000},
        {2'd3, 1'b1, 5'd0,  5'd2,  16'h0000, 16'h8001},
        {2'd0, 1'b1, 5'd21, 5'd10, 16'hFFFF, 16'h0000},
        {2'd1, 1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000}
    };

    always @(posedge clk) cyc <= cyc + 1;

    // PHY-side observer: captures each bit at the MDC rise and measures the period.
    always @(posedge mdc) begin
        #1;
        if (rises < 64) begin
            cap_o[rises]  = mdio_o;
            cap_oe[rises] = mdio_oe;
        end
        if (rises > 0) begin
            if (cyc - last_rise < per_min) per_min = cyc - last_rise;
            if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        rises = rises + 1;
    end

    // PHY-side driver: presents read data after a falling MDC edge.
    always @(negedge mdc)
        mdio_i <= (rises >= 48 && rises < 64) ? phy_data[63 - rises] : 1'b1;

    function automatic logic [31:0] mk_word(logic rd, logic [4:0] phy, logic [4:0] rg,
                                            logic [15:0] data);
        return {2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, data};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic start_frame(input logic [1:0] sel, input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_port_en = 1'b1; cfg_div_sel = sel;
        @(negedge clk);
        cfg_wr = 1'b0;
        rises = 0; per_min = 100000; per_max = 0;
        cmd_wr = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_done(output int busy_cnt, output int high_cnt);
        busy_cnt = 0; high_cnt = 0;
        while (idle === 1'b0 && busy_cnt < 10000) begin
            busy_cnt++;
            if (mdc) high_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic check_bits(input logic [31:0] w, input logic rd, input string tag);
        int bad_o = 0;
        int bad_oe = 0;
        for (int i = 0; i < 64; i++) begin
            logic eb;
            logic eoe;
            eb  = (i < 32) ? 1'b1 : w[63 - i];
            eoe = !(rd && i >= 46);
            if (cap_oe[i] !== eoe) bad_oe++;
            if (eoe && cap_o[i] !== eb) bad_o++;
        end
        check(bad_o == 0, "R3", {tag, " frame bits"}, bad_o, 0);
        check(bad_oe == 0, "R5", {tag, " drive enable"}, bad_oe, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        summary();
        $finish;
    end

    initial begin
        int bc;
        int hc;
        int n;
        logic [31:0] w;
        logic [31:0] wa;
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(idle === 1'b1, "R1", "idle after reset", idle, 1);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "mdc/oe after reset", {mdc, mdio_oe}, 0);
        check(mgmt_word === 32'h0, "R1", "word after reset", mgmt_word, 0);

        // Table of frames
        for (int k = 0; k < 6; k++) begin
            logic [44:0] v;
            v = VEC[k];
            n = 8 << v[44:43];
            w = mk_word(v[42], v[41:37], v[36:32], v[31:16]);
            phy_data = v[15:0];
            start_frame(v[44:43], w);
            check(idle === 1'b0, "R7", "idle low after accept", idle, 0);
            wait_done(bc, hc);
            check(bc == 64 * n, "R7", "frame length", bc, 64 * n);
            check(per_min == n && per_max == n, "R2", "mdc period", per_max, n);
            check(hc == 32 * n, "R2", "mdc high time", hc, 32 * n);
            check(rises == 64, "R3", "mdc edges", rises, 64);
            check_bits(w, v[42], "table");
            check(mgmt_word === (v[42] ? {w[31:16], v[15:0]} : w), "R6", "readback",
                  mgmt_word, v[42] ? {w[31:16], v[15:0]} : w);
            check(mdc === 1'b0 && mdio_oe === 1'b0, "R11", "quiet after frame",
                  {mdc, mdio_oe}, 0);
        end

        // R8: a second command during a frame is ignored
        wa = mk_word(1'b0, 5'd3, 5'd4, 16'hBEEF);
        start_frame(2'd0, wa);
        repeat (100) @(negedge clk);
        cmd_wr = 1'b1; cmd_word = mk_word(1'b1, 5'd9, 5'd9, 16'h0F0F);
        @(negedge clk);
        cmd_wr = 1'b0;
        wait_done(bc, hc);
        check(bc == 64 * 8 - 101, "R8", "frame length unchanged", bc, 64 * 8 - 101);
        check_bits(wa, 1'b0, "R8");
        check(mgmt_word === wa, "R8", "word kept", mgmt_word, wa);

        // R9: command with the port disabled is ignored
        @(negedge clk);
        cfg_wr = 1'b1; cfg_port_en = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        rises = 0;
        prev = mgmt_word;
        cmd_wr = 1'b1; cmd_word = mk_word(1'b0, 5'd7, 5'd7, 16'h5555);
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (50) @(negedge clk);
        check(idle === 1'b1, "R9", "idle stays high", idle, 1);
        check(rises == 0, "R9", "no mdc edge", rises, 0);
        check(mgmt_word === prev, "R9", "word unchanged", mgmt_word, prev);

        // R10: clearing the enable aborts a frame in progress
        start_frame(2'd1, mk_word(1'b1, 5'd2, 5'd3, 16'h0000));
        repeat (200) @(negedge clk);
        check(idle === 1'b0, "R10", "frame running before abort", idle, 0);
        cfg_wr = 1'b1; cfg_port_en = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(idle === 1'b1, "R10", "idle after abort", idle, 1);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R10", "line released", {mdc, mdio_oe}, 0);
        prev = rises;
        repeat (100) @(negedge clk);
        check(rises == prev, "R10", "no mdc after abort", rises, prev);

        summary();
        $finish;
    end
endmodule